// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block evaluates integer expressions without operand addresses. A command source presents one command at a time over a valid/ready handshake: push a data word, pop the top word, or apply add, subtract, multiply or divide to the two uppermost entries. An arithmetic command consumes both operands from an internal stack of registers and leaves its single result on top, so a postfix sequence such as push X, push Y, add, push Q, push Z, subtract, divide leaves (X+Y)/(Q-Z) on top.

The stack is a fixed array of data words. The current top entry and the entry count are always visible. Popped words come back on a one-cycle result strobe. Three flags describe the outcome of the most recent command: overflow, underflow and divide-by-zero. Add, subtract, multiply, push and pop finish in one cycle. Divide runs a restoring divider that produces one quotient bit per cycle, and the handshake stays busy until the quotient has been written.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset, depth_o is 0, tos_o is 0, all three flags are 0, cmd_ready_o is 1 and pop_valid_o is 0.
- R2: A command is taken on a rising edge where cmd_valid_i and cmd_ready_o are both 1. cmd_op_i 0 is PUSH: cmd_data_i becomes tos_o and depth_o rises by one, both visible after that edge.
- R3: cmd_op_i 1 is POP. On a non-empty stack, pop_valid_o is 1 for exactly the one cycle after acceptance, with pop_data_o equal to the old top, and depth_o falls by one.
- R4: cmd_op_i 2 (ADD) and 4 (MUL) replace the two top entries with their sum or the low 32 bits of their product, both modulo 2^32. depth_o falls by one.
- R5: cmd_op_i 3 (SUB) replaces the two top entries with the entry below the top minus the top, modulo 2^32.
- R6: cmd_op_i 5 (DIV) with a nonzero top replaces the two top entries with the unsigned quotient of the entry below the top divided by the top. cmd_ready_o is 0 from the cycle after acceptance until the quotient is on top.
- R7: An ADD, SUB, MUL or DIV with fewer than two entries, or a POP on an empty stack, sets unf_o and leaves the stack and depth unchanged. pop_valid_o stays 0.
- R8: A PUSH with 16 entries present sets ovf_o and is discarded: depth_o stays 16 and tos_o is unchanged.
- R9: A DIV whose top entry is 0 completes in one cycle without lowering cmd_ready_o. It replaces the two entries with 32'hFFFF_FFFF and sets div_err_o.
- R10: Each accepted command overwrites all three flags with its own outcome. cmd_op_i 6 and 7 are no-operations that clear the flags and change nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit can take a command |
| cmd_op_i | input | 3 | Command code (see R2 to R10) |
| cmd_data_i | input | 32 | Word to push |
| pop_valid_o | output | 1 | Popped word strobe |
| pop_data_o | output | 32 | Popped word |
| tos_o | output | 32 | Current top entry, 0 when empty |
| depth_o | output | 5 | Number of entries held |
| ovf_o | output | 1 | Last command was a push on a full stack |
| unf_o | output | 1 | Last command lacked operands |
| div_err_o | output | 1 | Last command divided by zero |

## Verification
A corrupted stack pointer shows up at once on depth_o, and within one command on tos_o or on a popped word that differs from the scoreboard entry. A wrong operand order or a bad divider iteration changes the value left on top, and this is visible as soon as ready returns. Deliberately filling the stack to 16 entries and then draining it exposes off-by-one errors in the full and empty detection. A divider whose busy window is wrong shows as ready returning early or never, and the watchdog catches a unit that stays busy.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_NOP6 = 3'd6,
    OP_NOP7 = 3'd7
  } stk_op_e;
endpackage

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))         mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  stk_op_e           op_i,
  input  logic [DATA_W-1:0] nos_i,
  input  logic [DATA_W-1:0] tos_i,
  output logic [DATA_W-1:0] res_o
);
  logic [2*DATA_W-1:0] prod;
  assign prod = nos_i * tos_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = nos_i + tos_i;
      OP_SUB:  res_o = nos_i - tos_i;
      OP_MUL:  res_o = prod[DATA_W-1:0];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/stk_divider.sv
module stk_divider #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  logic [W-1:0]     rem_q, quo_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [W:0]       rem_sh, rem_sub;
  logic             ge;

  // restoring step: shift in next dividend bit, subtract if it fits
  assign rem_sh  = {rem_q, quo_q[W-1]};
  assign ge      = rem_sh >= {1'b0, dvs_q};
  assign rem_sub = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      dvs_q  <= divisor_i;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= ge ? rem_sub[W-1:0] : rem_sh[W-1:0];
      quo_q <= {quo_q[W-2:0], ge};
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  a_r6_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_q));
  a_r6_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [DATA_W-1:0] tos_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              div_err_o
);
  stk_op_e           op;
  logic [CNT_W-1:0]  depth_q, depth_d;
  logic              pend_q;
  logic              accept, empty, full, has_two;
  logic [DATA_W-1:0] rd_tos, rd_nos, alu_res, quot;
  logic              we;
  logic [IDX_W-1:0]  waddr;
  logic [DATA_W-1:0] wdata;
  logic              div_start, div_busy, div_done;
  logic              ovf_d, unf_d, derr_d, pop_d;
  logic              ovf_q, unf_q, derr_q, pop_q;
  logic [DATA_W-1:0] pop_data_q;

  assign op          = stk_op_e'(cmd_op_i);
  assign cmd_ready_o = !pend_q;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign empty       = depth_q == '0;
  assign full        = depth_q == CNT_W'(DEPTH);
  assign has_two     = depth_q >= CNT_W'(2);

  stk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (IDX_W'(depth_q - CNT_W'(1))),
    .rdata_a_o (rd_tos),
    .raddr_b_i (IDX_W'(depth_q - CNT_W'(2))),
    .rdata_b_o (rd_nos)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op),
    .nos_i (rd_nos),
    .tos_i (rd_tos),
    .res_o (alu_res)
  );

  stk_divider #(.W(DATA_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (rd_nos),
    .divisor_i  (rd_tos),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  always_comb begin
    we        = 1'b0;
    waddr     = IDX_W'(depth_q - CNT_W'(2));
    wdata     = alu_res;
    depth_d   = depth_q;
    div_start = 1'b0;
    ovf_d     = 1'b0;
    unf_d     = 1'b0;
    derr_d    = 1'b0;
    pop_d     = 1'b0;
    if (div_done) begin
      we      = 1'b1;
      wdata   = quot;
      depth_d = depth_q - CNT_W'(1);
    end else if (accept) begin
      unique case (op)
        OP_PUSH: begin
          if (full) ovf_d = 1'b1;
          else begin
            we      = 1'b1;
            waddr   = IDX_W'(depth_q);
            wdata   = cmd_data_i;
            depth_d = depth_q + CNT_W'(1);
          end
        end
        OP_POP: begin
          if (empty) unf_d = 1'b1;
          else begin
            pop_d   = 1'b1;
            depth_d = depth_q - CNT_W'(1);
          end
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          if (!has_two) unf_d = 1'b1;
          else begin
            we      = 1'b1;
            depth_d = depth_q - CNT_W'(1);
          end
        end
        OP_DIV: begin
          if (!has_two) unf_d = 1'b1;
          else if (rd_tos == '0) begin
            we      = 1'b1;
            wdata   = '1;
            derr_d  = 1'b1;
            depth_d = depth_q - CNT_W'(1);
          end else begin
            div_start = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q    <= '0;
      pend_q     <= 1'b0;
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
      derr_q     <= 1'b0;
      pop_q      <= 1'b0;
      pop_data_q <= '0;
    end else begin
      depth_q <= depth_d;
      pop_q   <= pop_d;
      if (pop_d) pop_data_q <= rd_tos;
      if (div_start)     pend_q <= 1'b1;
      else if (div_done) pend_q <= 1'b0;
      if (accept) begin
        ovf_q  <= ovf_d;
        unf_q  <= unf_d;
        derr_q <= derr_d;
      end
    end
  end

  assign pop_valid_o = pop_q;
  assign pop_data_o  = pop_data_q;
  assign tos_o       = empty ? '0 : rd_tos;
  assign depth_o     = depth_q;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign div_err_o   = derr_q;

  a_r2_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= CNT_W'(DEPTH));
  a_r2_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_PUSH && !full) |=> (tos_o == $past(cmd_data_i)));
  a_r3_pop_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> $past(accept) && ($past(cmd_op_i) == 3'd1));
  a_r7_underflow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV} && !has_two)
      |=> unf_o && depth_q == $past(depth_q));
  a_r8_overflow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_PUSH && full) |=> ovf_o && $stable(tos_o) && depth_q == CNT_W'(DEPTH));
  a_r6_busy_after_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start |=> !cmd_ready_o);
  a_r10_flags_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o, div_err_o}));
endmodule

// File: tb/stk_exec_unit_tb_top.sv
module stk_exec_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [2:0]  cmd_op_i = 3'd0;
  logic [31:0] cmd_data_i = '0;
  logic        pop_valid_o;
  logic [31:0] pop_data_o;
  logic [31:0] tos_o;
  logic [4:0]  depth_o;
  logic        ovf_o, unf_o, div_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  stk_exec_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i), .pop_valid_o(pop_valid_o),
    .pop_data_o(pop_data_o), .tos_o(tos_o), .depth_o(depth_o), .ovf_o(ovf_o),
    .unf_o(unf_o), .div_err_o(div_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_data_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] d); send(3'd0, d); endtask

  task automatic pop_exp(input logic [31:0] e);
    exp_q.push_back(e);
    send(3'd1, '0);
  endtask

  task automatic wait_idle;
    while (!cmd_ready_o) @(negedge clk_i);
  endtask

  task automatic flags(input string req, input logic [2:0] e);
    chk(req, {29'd0, ovf_o, unf_o, div_err_o}, {29'd0, e});
  endtask

  // monitor: compares popped words against scoreboard queue
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && pop_valid_o) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R3/R7: unexpected pop actual %h expected none", pop_data_o);
        end else chk("R3 pop data", pop_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 depth", {27'd0, depth_o}, 0);
    chk("R1 tos", tos_o, 0);
    flags("R1 flags", 3'b000);
    chk("R1 ready", {31'd0, cmd_ready_o}, 1);
    chk("R1 pop_valid", {31'd0, pop_valid_o}, 0);
    rst_ni = 1'b1;

    // R7 underflow on empty stack
    send(3'd2, '0);
    flags("R7 add empty", 3'b010);
    chk("R7 depth", {27'd0, depth_o}, 0);
    send(3'd1, '0);
    chk("R7 pop empty no strobe", {31'd0, pop_valid_o}, 0);
    flags("R7 pop empty", 3'b010);

    // R2 push, R10 flags cleared
    push(32'd3);
    chk("R2 tos", tos_o, 3);
    chk("R2 depth", {27'd0, depth_o}, 1);
    flags("R10 cleared by push", 3'b000);
    send(3'd3, '0);
    flags("R7 sub one entry", 3'b010);
    chk("R7 tos kept", tos_o, 3);
    chk("R7 depth kept", {27'd0, depth_o}, 1);
    push(32'd5);
    // R5 3 - 5 wraps
    send(3'd3, '0);
    chk("R5 sub", tos_o, 32'hFFFF_FFFE);
    chk("R5 depth", {27'd0, depth_o}, 1);
    pop_exp(32'hFFFF_FFFE);
    chk("R3 pop strobe", {31'd0, pop_valid_o}, 1);
    chk("R3 depth", {27'd0, depth_o}, 0);

    // R4 add wrap and multiply low word
    push(32'hFFFF_FFFF); push(32'd2); send(3'd2, '0);
    chk("R4 add", tos_o, 32'd1);
    push(32'h0001_0003); push(32'h0001_0000); send(3'd4, '0);
    chk("R4 mul", tos_o, 32'h0003_0000);
    chk("R4 depth", {27'd0, depth_o}, 2);
    pop_exp(32'h0003_0000); pop_exp(32'd1);

    // R6 (X+Y)/(Q-Z)
    push(32'd20); push(32'd40); send(3'd2, '0);
    push(32'd9); push(32'd3); send(3'd3, '0);
    send(3'd5, '0);
    chk("R6 ready low", {31'd0, cmd_ready_o}, 0);
    wait_idle();
    chk("R6 expr", tos_o, 32'd10);
    chk("R6 depth", {27'd0, depth_o}, 1);
    pop_exp(32'd10);
    push(32'd100); push(32'd7); send(3'd5, '0); wait_idle();
    chk("R6 100/7", tos_o, 32'd14);
    push(32'd100); send(3'd5, '0); wait_idle();
    chk("R6 14/100", tos_o, 32'd0);
    pop_exp(32'd0);

    // R9 divide by zero
    push(32'd8); push(32'd0); send(3'd5, '0);
    chk("R9 ready stays", {31'd0, cmd_ready_o}, 1);
    chk("R9 result", tos_o, 32'hFFFF_FFFF);
    flags("R9 div_err", 3'b001);
    chk("R9 depth", {27'd0, depth_o}, 1);
    send(3'd6, 32'd77);
    flags("R10 nop clears", 3'b000);
    chk("R10 nop tos", tos_o, 32'hFFFF_FFFF);
    chk("R10 nop depth", {27'd0, depth_o}, 1);
    pop_exp(32'hFFFF_FFFF);

    // R8 fill and overflow
    for (int i = 0; i < 16; i++) push(32'(i * 3 + 1));
    chk("R8 full depth", {27'd0, depth_o}, 16);
    push(32'hDEAD_BEEF);
    flags("R8 ovf", 3'b100);
    chk("R8 depth", {27'd0, depth_o}, 16);
    chk("R8 tos kept", tos_o, 32'd46);
    for (int i = 15; i >= 0; i--) pop_exp(32'(i * 3 + 1));
    chk("R3 drained", {27'd0, depth_o}, 0);
    repeat (2) @(negedge clk_i);
    chk("R3 scoreboard empty", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule